// File: doc/BRIEF.md
# Configurable Interrupt Controller

A memory-mapped interrupt controller that gathers 32 interrupt sources into one critical and one non-critical request line. Every source goes through a two-flop synchronizer. Each source then has its own trigger mode (level or edge) and its own active sense. A detected event sets a sticky status bit. Software changes status only through two alias addresses: one where writing 1 clears a bit and one where writing 1 sets a bit.

An enable mask selects which status bits can raise a request. The masked result can be read at its own address, and software cannot write it. A per-source critical bit sends each enabled bit to one of the two request outputs. A vector read returns a base value that software stores, plus the number of the most urgent pending critical source.

Top module: `irq_ctrl`

## Requirements
- R1: Source n appears at data bit 31-n in every register. The byte offsets are: 0x00 status (read and clear), 0x04 status set, 0x08 enable, 0x0C critical, 0x10 polarity, 0x14 trigger, 0x18 masked status (read only), 0x1C vector (read only) and 0x20 vector base (write only).
- R2: A status bit stays set until software clears it.
- R3: Writing to 0x00 clears each status bit whose data bit is 1 and leaves the bits written as 0 unchanged. A read of 0x00 returns the current status.
- R4: Writing to 0x04 sets each status bit whose data bit is 1, and data bits of 0 have no effect. A read of 0x04 also returns the current status.
- R5: With trigger bit 1, the source is edge sensitive: polarity 1 selects a rising edge and polarity 0 a falling edge. Each edge sets the status bit once. Status reflects an input change on the third rising clock edge after it.
- R6: With trigger bit 0, the source is level sensitive: polarity 1 means active high and polarity 0 means active low. Status is set again on every cycle the level stays active, so a clear has no effect while the level persists, because a hardware set wins over a software clear.
- R7: Status capture does not depend on the enable or critical settings.
- R8: Offset 0x18 returns status AND enable. Writes to 0x18 and 0x1C change nothing.
- R9: crit_irq_o is the OR of the masked bits whose critical bit is 1. ncrit_irq_o is the OR of the remaining masked bits.
- R10: Offset 0x1C returns the vector base plus the lowest-numbered source that is pending, enabled and critical. It returns 0 when no such source exists. A read of 0x20 returns 0.
- R11: Reset clears every register. Because polarity and trigger also reset to zero, every source starts as active-low level sensitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt sources; index n is source n |
| addr_i | input | 6 | Byte address of the register |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when re_i is low |
| crit_irq_o | output | 1 | Critical interrupt request |
| ncrit_irq_o | output | 1 | Non-critical interrupt request |

## Verification
The hardest case to reach is a software clear landing while a level-sensitive source is still asserted. The bench holds one source at its active level, issues a full clear and then reads status back, which must show the bit still set. It then releases the source and confirms that the next clear does take effect. One-shot edge behaviour is reached by holding all inputs high for several cycles after a rising edge and checking that a clear sticks. Each source is driven one at a time in a sweep, with enable held at zero, to check the bit position and that capture is independent of enable.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int ADDR_W = 6;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT  = 6'h00,
    REG_SET   = 6'h04,
    REG_EN    = 6'h08,
    REG_CRIT  = 6'h0C,
    REG_POL   = 6'h10,
    REG_TRIG  = 6'h14,
    REG_MSTAT = 6'h18,
    REG_VEC   = 6'h1C,
    REG_VBASE = 6'h20
  } reg_off_e;
endpackage

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] pol_i,
  input  logic [N_SRC-1:0] trig_i,
  output logic [N_SRC-1:0] ev_o
);
  logic [N_SRC-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    logic edge_hit, lvl_hit;
    assign edge_hit = pol_i[n] ? (sync_q[n] & ~prev_q[n]) : (~sync_q[n] & prev_q[n]);
    assign lvl_hit  = (sync_q[n] == pol_i[n]);
    assign ev_o[n]  = trig_i[n] ? edge_hit : lvl_hit;

    // an edge event never repeats on consecutive cycles under fixed config
    AST_EDGE_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i[n] && ev_o[n]) |=> !(ev_o[n] && trig_i[n] && $stable(pol_i[n]))); // R5
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N_SRC = 32,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign vld_o = |req_i;

  always_comb begin
    if (vld_o) AST_PRIO_HIT: assert (req_i[idx_o]); // R10
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC = 32,
  localparam int DATA_W = N_SRC,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              crit_irq_o,
  output logic              ncrit_irq_o
);
  // internal vectors are indexed by source number; bus bit = N-1-source
  function automatic logic [N_SRC-1:0] flip(input logic [N_SRC-1:0] v);
    for (int i = 0; i < N_SRC; i++) flip[i] = v[N_SRC-1-i];
  endfunction

  logic [N_SRC-1:0]  stat_q, en_q, crit_q, pol_q, trig_q;
  logic [DATA_W-1:0] vbase_q;
  logic [N_SRC-1:0]  ev_w, wmask, clr_mask, set_mask, mstat, crit_req;
  logic              vec_vld;
  logic [IDX_W-1:0]  vec_idx;

  assign wmask    = flip(wdata_i);
  assign clr_mask = (we_i && addr_i == REG_STAT) ? wmask : '0;
  assign set_mask = (we_i && addr_i == REG_SET)  ? wmask : '0;

  irq_detect #(.N_SRC(N_SRC)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .pol_i  (pol_q),
    .trig_i (trig_q),
    .ev_o   (ev_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      en_q    <= '0;
      crit_q  <= '0;
      pol_q   <= '0;
      trig_q  <= '0;
      vbase_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | set_mask | ev_w; // hw set wins
      if (we_i) begin
        case (addr_i)
          REG_EN:    en_q    <= wmask;
          REG_CRIT:  crit_q  <= wmask;
          REG_POL:   pol_q   <= wmask;
          REG_TRIG:  trig_q  <= wmask;
          REG_VBASE: vbase_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign mstat    = stat_q & en_q;
  assign crit_req = mstat & crit_q;

  irq_prio #(.N_SRC(N_SRC)) u_prio (
    .req_i (crit_req),
    .vld_o (vec_vld),
    .idx_o (vec_idx)
  );

  assign crit_irq_o  = |crit_req;
  assign ncrit_irq_o = |(mstat & ~crit_q);

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      case (addr_i)
        REG_STAT, REG_SET: rdata_o = flip(stat_q);
        REG_EN:            rdata_o = flip(en_q);
        REG_CRIT:          rdata_o = flip(crit_q);
        REG_POL:           rdata_o = flip(pol_q);
        REG_TRIG:          rdata_o = flip(trig_q);
        REG_MSTAT:         rdata_o = flip(mstat);
        REG_VEC:           rdata_o = vec_vld ? vbase_q + DATA_W'(vec_idx) : '0;
        default:           rdata_o = '0;
      endcase
    end
  end

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == REG_STAT) |=> (($past(stat_q) & ~stat_q) == '0)); // R2
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_STAT && ev_w == '0) |=> ((stat_q & $past(wmask)) == '0)); // R3
  AST_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_SET) |=> ((stat_q & $past(wmask)) == $past(wmask))); // R4
  AST_NO_EN_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !(crit_irq_o || ncrit_irq_o)); // R9
endmodule

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [31:0] src_i = '0;
  logic [5:0]  addr_i = '0;
  logic        we_i = 0, re_i = 0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        crit_irq_o, ncrit_irq_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;
  logic [31:0] d;

  always #10 clk_i = ~clk_i;

  irq_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .addr_i(addr_i),
    .we_i(we_i), .re_i(re_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .crit_irq_o(crit_irq_o), .ncrit_irq_o(ncrit_irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk_i);
    addr_i = a; wdata_i = v; we_i = 1;
    @(posedge clk_i);
    #1 we_i = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk_i);
    addr_i = a; re_i = 1;
    #1 v = rdata_o;
    re_i = 0;
  endtask

  task automatic cyc(input int k);
    repeat (k) @(posedge clk_i);
  endtask

  initial begin
    // R11 reset state
    #5;
    rd(6'h08, d); chk("R11 enable", d, 0);
    rd(6'h0C, d); chk("R11 critical", d, 0);
    rd(6'h10, d); chk("R11 polarity", d, 0);
    rd(6'h14, d); chk("R11 trigger", d, 0);
    chk("R11 irq outputs", {30'd0, crit_irq_o, ncrit_irq_o}, 0);
    @(negedge clk_i) rst_ni = 1;
    cyc(3);
    // R6/R11: defaults are active-low level, inputs low
    rd(6'h00, d); chk("R6 default active-low level", d, 32'hFFFF_FFFF);
    wr(6'h10, 32'hFFFF_FFFF);
    cyc(3);
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, d); chk("R3 clear all", d, 0);
    // R4 set alias, R3 partial clear
    wr(6'h04, 32'hA5A5_0F0F);
    rd(6'h00, d); chk("R4 set via alias", d, 32'hA5A5_0F0F);
    rd(6'h04, d); chk("R4 read at set alias", d, 32'hA5A5_0F0F);
    wr(6'h04, 32'h0);
    rd(6'h00, d); chk("R4 zero write no effect", d, 32'hA5A5_0F0F);
    wr(6'h00, 32'h0000_FFFF);
    rd(6'h00, d); chk("R3 partial clear", d, 32'hA5A5_0000);
    cyc(2);
    rd(6'h00, d); chk("R2 sticky", d, 32'hA5A5_0000);
    wr(6'h00, 32'hFFFF_FFFF);
    // R1/R7 mapping sweep with enable at zero
    for (int n = 0; n < 32; n++) begin
      @(negedge clk_i) src_i = 32'd1 << n;
      cyc(4);
      @(negedge clk_i) src_i = '0;
      cyc(4);
      rd(6'h00, d); chk("R1 R7 source bit position", d, 32'h8000_0000 >> n);
      wr(6'h00, 32'hFFFF_FFFF);
    end
    // R6 level held: clear ineffective
    @(negedge clk_i) src_i = 32'd1 << 3;
    cyc(4);
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, d); chk("R6 clear loses to active level", d, 32'h1000_0000);
    @(negedge clk_i) src_i = '0;
    cyc(4);
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, d); chk("R6 clear after release", d, 0);
    // R5 edge mode: sources 0..15 rising, 16..31 falling
    wr(6'h14, 32'hFFFF_FFFF);
    wr(6'h10, 32'hFFFF_0000);
    cyc(3);
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, d); chk("R5 quiet after config", d, 0);
    @(negedge clk_i) src_i = 32'hFFFF_FFFF;
    cyc(2);
    rd(6'h00, d); chk("R5 latency not yet", d, 0);
    rd(6'h00, d); chk("R5 rising edge captured", d, 32'hFFFF_0000);
    cyc(6);
    wr(6'h00, 32'hFFFF_FFFF);
    cyc(2);
    rd(6'h00, d); chk("R5 one event per edge", d, 0);
    @(negedge clk_i) src_i = '0;
    cyc(4);
    rd(6'h00, d); chk("R5 falling edge captured", d, 32'h0000_FFFF);
    wr(6'h00, 32'hFFFF_FFFF);
    // R8 masked view
    wr(6'h04, 32'hF0F0_F0F0);
    wr(6'h08, 32'hFF00_FF00);
    rd(6'h18, d); chk("R8 masked status", d, 32'hF000_F000);
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h1C, 32'hFFFF_FFFF);
    rd(6'h18, d); chk("R8 masked write ignored", d, 32'hF000_F000);
    rd(6'h00, d); chk("R8 status untouched", d, 32'hF0F0_F0F0);
    // R9 routing
    wr(6'h0C, 32'h0);
    chk("R9 all noncritical", {30'd0, crit_irq_o, ncrit_irq_o}, 32'd1);
    wr(6'h0C, 32'hFFFF_0000);
    chk("R9 split", {30'd0, crit_irq_o, ncrit_irq_o}, 32'd3);
    wr(6'h0C, 32'hFFFF_FFFF);
    chk("R9 all critical", {30'd0, crit_irq_o, ncrit_irq_o}, 32'd2);
    wr(6'h08, 32'h0);
    chk("R9 disabled", {30'd0, crit_irq_o, ncrit_irq_o}, 32'd0);
    wr(6'h00, 32'hFFFF_FFFF);
    // R10 vector
    wr(6'h20, 32'h0000_1000);
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h1C, d); chk("R10 none pending", d, 0);
    rd(6'h20, d); chk("R10 base reads zero", d, 0);
    wr(6'h04, 32'h0010_0001);
    rd(6'h1C, d); chk("R10 lowest source wins", d, 32'h0000_100B);
    wr(6'h00, 32'h0010_0000);
    rd(6'h1C, d); chk("R10 next source", d, 32'h0000_101F);
    wr(6'h0C, 32'hFFFF_FFFE);
    rd(6'h1C, d); chk("R10 noncritical excluded", d, 0);
    wr(6'h0C, 32'hFFFF_FFFF);
    wr(6'h00, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      wr(6'h04, 32'h8000_0000 >> n);
      rd(6'h1C, d); chk("R10 vector sweep", d, 32'h0000_1000 + n);
      wr(6'h00, 32'hFFFF_FFFF);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    cyc(200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule